// File: doc/BRIEF.md
# Exception Entry Unit

This block performs the state changes a small processor core makes when it enters an exception handler. It takes a general exception request with a cause code, a misaligned-access request and a bus-address-error request. It also takes a debug request and the current PC. When it accepts a request, it saves the PC and status into dedicated registers, records the cause and, where relevant, the faulting virtual address, and updates the internal status word. One cycle later it raises a single-cycle take pulse together with an encoded vector ID. A later stage turns that ID into a fetch address.

The status word is eight bits wide. Bits [3:0] hold the current interrupt level, bit 4 is the exception-mode flag and bit 5 is the user-mode flag. Bits [7:6] are kept as loaded. The status word can be loaded from outside, for example on an exception return. Every saved register can be inspected through a small combinational read port. The vector IDs are: 0 none, 1 kernel, 2 user, 3 double exception, 4 debug.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset the status word, the cause, faulting-address, debug-cause, double-exception PC, level-1 PC, debug-level PC and debug-level saved-status registers all read 0, `take_o` is 0 and `vec_o` is 0.
- R2: A general exception entered with status bit 4 clear writes `cur_pc` to the level-1 saved-PC register. It reports vector 2 when status bit 5 is set and vector 1 otherwise.
- R3: A general exception entered with status bit 4 set reports vector 3 whatever bit 5 holds. With `HAS_DEPC`=1 (default) the PC goes to the double-exception PC register and the level-1 PC is left unchanged. With `HAS_DEPC`=0 the PC goes to the level-1 PC register.
- R4: Every general exception writes its cause code into the cause register and sets status bit 4. `take_o` goes high in the cycle after the request is sampled and stays high for exactly one cycle.
- R5: An exception that carries an address loads the faulting-address register with that address. These are `exc_req` with `exc_addr_vld`=1, a qualified misaligned access, and a bus error. Any other exception leaves that register unchanged.
- R6: A debug request is accepted only when status bits [3:0] are strictly below `DBG_LEVEL` (default 6). Otherwise it has no effect.
- R7: A taken debug exception does the following:
  - it writes `dbg_cause` into the debug-cause register;
  - it saves `cur_pc` in the debug-level PC register and the old status word in the debug-level saved-status register;
  - it sets status bits [3:0] to `DBG_LEVEL` and sets bit 4, keeping bits [7:5];
  - it reports vector 4.
- R8: A misaligned-access request becomes an exception with cause `CAUSE_ALIGN` (default 9) only when `align_trap_en`=1 and `hw_align_en`=0. Otherwise it is dropped.
- R9: A bus error raises cause `CAUSE_IFETCH_BUS` (default 12) with `buserr_fetch_addr` when `buserr_is_fetch`=1. Otherwise it raises cause `CAUSE_DATA_BUS` (default 13) with `buserr_data_addr`.
- R10: Simultaneous requests are served in this order: accepted debug, then `exc_req`, then bus error, then misaligned access. Any request present in a cycle where `take_o` is high is dropped.
- R11: `st_load` writes `st_load_val` into the status word at the next edge. An exception entered at the same edge wins, using the status held before that edge.
- R12: The `rd_sel` codes are: 0 status, 1 cause, 2 faulting address, 3 debug cause, 4 double-exception PC, 5 level-1 PC, 6 debug-level PC, 7 debug-level saved status. The selected value appears zero-extended on `rd_data` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pc | input | XLEN | PC of the instruction raising the request |
| exc_req | input | 1 | General exception request |
| exc_cause | input | CAUSE_W | Cause code of the general request |
| exc_addr_vld | input | 1 | General request carries a faulting address |
| exc_addr | input | XLEN | Faulting virtual address of the general request |
| misalign_req | input | 1 | Misaligned access detected |
| misalign_addr | input | XLEN | Address of the misaligned access |
| align_trap_en | input | 1 | Misaligned accesses may trap |
| hw_align_en | input | 1 | Hardware handles misaligned accesses |
| buserr_req | input | 1 | Bus address error |
| buserr_is_fetch | input | 1 | Bus error came from instruction fetch |
| buserr_fetch_addr | input | XLEN | Fetch address of the failed access |
| buserr_data_addr | input | XLEN | Data virtual address of the failed access |
| dbg_req | input | 1 | Debug exception request |
| dbg_cause | input | DBGC_W | Debug cause bits |
| st_load | input | 1 | Load the status word |
| st_load_val | input | 8 | Value for the status word |
| rd_sel | input | 3 | Read-port register select |
| rd_data | output | XLEN | Read-port data |
| take_o | output | 1 | One-cycle exception-taken pulse |
| vec_o | output | 3 | Vector ID of the last taken exception |

## Verification
The hardest situations to reach are the collisions. These are a debug request together with a general one, several general sources in the same cycle, and a request still held while the previous take pulse is high. Each must leave exactly one set of register updates. The bench reaches them with directed steps that drive two or three request inputs in the same cycle. It reads the cause and address registers before and after, so it can see which source won and that the loser left no trace. Double-exception and debug-refusal cases are reached by preloading the status word through the load port before each table vector.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int ST_W        = 8;
  localparam int ILVL_W      = 4;
  localparam int ST_EXCM_BIT = 4;
  localparam int ST_UM_BIT   = 5;

  typedef enum logic [2:0] {
    VEC_NONE   = 3'd0,
    VEC_KERNEL = 3'd1,
    VEC_USER   = 3'd2,
    VEC_DOUBLE = 3'd3,
    VEC_DEBUG  = 3'd4
  } vec_id_e;

  localparam logic [2:0] RD_STATUS  = 3'd0;
  localparam logic [2:0] RD_CAUSE   = 3'd1;
  localparam logic [2:0] RD_VADDR   = 3'd2;
  localparam logic [2:0] RD_DBGC    = 3'd3;
  localparam logic [2:0] RD_DEPC    = 3'd4;
  localparam logic [2:0] RD_EPC1    = 3'd5;
  localparam logic [2:0] RD_EPCDBG  = 3'd6;
  localparam logic [2:0] RD_EPSDBG  = 3'd7;

  // vector for a general exception given the two mode flags
  function automatic vec_id_e general_vector(input logic excm, input logic um);
    if (excm)    return VEC_DOUBLE;
    else if (um) return VEC_USER;
    else         return VEC_KERNEL;
  endfunction

  // debug accepted only below the configured level
  function automatic logic debug_allowed(input logic [ILVL_W-1:0] cur,
                                         input logic [ILVL_W-1:0] dbg);
    return cur < dbg;
  endfunction

  // status word after debug entry
  function automatic logic [ST_W-1:0] debug_status(input logic [ST_W-1:0] st,
                                                   input logic [ILVL_W-1:0] lvl);
    logic [ST_W-1:0] r;
    r = st;
    r[ILVL_W-1:0]  = lvl;
    r[ST_EXCM_BIT] = 1'b1;
    return r;
  endfunction

  // misaligned access only traps when software handling is selected
  function automatic logic align_traps(input logic trap_en, input logic hw_en);
    return trap_en & ~hw_en;
  endfunction

endpackage

// File: rtl/exc_src_qual.sv
module exc_src_qual
  import exc_entry_pkg::*;
#(
  parameter int XLEN             = 32,
  parameter int CAUSE_W          = 6,
  parameter int CAUSE_ALIGN      = 9,
  parameter int CAUSE_IFETCH_BUS = 12,
  parameter int CAUSE_DATA_BUS   = 13
) (
  input  logic               exc_req,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic               exc_addr_vld,
  input  logic [XLEN-1:0]    exc_addr,
  input  logic               misalign_req,
  input  logic [XLEN-1:0]    misalign_addr,
  input  logic               align_trap_en,
  input  logic               hw_align_en,
  input  logic               buserr_req,
  input  logic               buserr_is_fetch,
  input  logic [XLEN-1:0]    buserr_fetch_addr,
  input  logic [XLEN-1:0]    buserr_data_addr,
  output logic               gen_vld,
  output logic [CAUSE_W-1:0] gen_cause,
  output logic               gen_addr_vld,
  output logic [XLEN-1:0]    gen_addr
);

  logic align_qual;
  assign align_qual = misalign_req & align_traps(align_trap_en, hw_align_en);

  // fixed order: explicit request, bus error, misaligned access
  always_comb begin
    gen_vld      = 1'b0;
    gen_cause    = '0;
    gen_addr_vld = 1'b0;
    gen_addr     = '0;
    if (exc_req) begin
      gen_vld      = 1'b1;
      gen_cause    = exc_cause;
      gen_addr_vld = exc_addr_vld;
      gen_addr     = exc_addr;
    end else if (buserr_req) begin
      gen_vld      = 1'b1;
      gen_addr_vld = 1'b1;
      if (buserr_is_fetch) begin
        gen_cause = CAUSE_W'(CAUSE_IFETCH_BUS);
        gen_addr  = buserr_fetch_addr;
      end else begin
        gen_cause = CAUSE_W'(CAUSE_DATA_BUS);
        gen_addr  = buserr_data_addr;
      end
    end else if (align_qual) begin
      gen_vld      = 1'b1;
      gen_cause    = CAUSE_W'(CAUSE_ALIGN);
      gen_addr_vld = 1'b1;
      gen_addr     = misalign_addr;
    end
  end

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
#(
  parameter int DBG_LEVEL = 6
) (
  input  logic              busy,
  input  logic              dbg_req,
  input  logic [ILVL_W-1:0] cur_lvl,
  input  logic              gen_vld,
  output logic              dbg_go,
  output logic              gen_go
);

  logic dbg_ok;
  assign dbg_ok = dbg_req & debug_allowed(cur_lvl, ILVL_W'(DBG_LEVEL));
  assign dbg_go = ~busy & dbg_ok;
  assign gen_go = ~busy & gen_vld & ~dbg_ok;

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int XLEN             = 32,
  parameter int CAUSE_W          = 6,
  parameter int DBGC_W           = 4,
  parameter int DBG_LEVEL        = 6,
  parameter int HAS_DEPC         = 1,
  parameter int CAUSE_ALIGN      = 9,
  parameter int CAUSE_IFETCH_BUS = 12,
  parameter int CAUSE_DATA_BUS   = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [XLEN-1:0]    cur_pc,
  input  logic               exc_req,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic               exc_addr_vld,
  input  logic [XLEN-1:0]    exc_addr,
  input  logic               misalign_req,
  input  logic [XLEN-1:0]    misalign_addr,
  input  logic               align_trap_en,
  input  logic               hw_align_en,
  input  logic               buserr_req,
  input  logic               buserr_is_fetch,
  input  logic [XLEN-1:0]    buserr_fetch_addr,
  input  logic [XLEN-1:0]    buserr_data_addr,
  input  logic               dbg_req,
  input  logic [DBGC_W-1:0]  dbg_cause,
  input  logic               st_load,
  input  logic [ST_W-1:0]    st_load_val,
  input  logic [2:0]         rd_sel,
  output logic [XLEN-1:0]    rd_data,
  output logic               take_o,
  output logic [2:0]         vec_o
);

  localparam logic [ILVL_W-1:0] DBG_LVL_V = ILVL_W'(DBG_LEVEL);
  localparam bit USE_DEPC = (HAS_DEPC != 0);

  logic [ST_W-1:0]    status_q;
  logic [CAUSE_W-1:0] cause_q;
  logic [XLEN-1:0]    vaddr_q;
  logic [DBGC_W-1:0]  dbgcause_q;
  logic [XLEN-1:0]    depc_q;
  logic [XLEN-1:0]    epc1_q;
  logic [XLEN-1:0]    epcdbg_q;
  logic [ST_W-1:0]    epsdbg_q;
  logic               take_q;
  vec_id_e            vec_q;

  // named events for checking
  logic               gen_vld, gen_addr_vld;
  logic [CAUSE_W-1:0] gen_cause;
  logic [XLEN-1:0]    gen_addr;
  logic               dbg_go, gen_go;
  logic               enter_double;
  logic               write_epc1;

  exc_src_qual #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .CAUSE_ALIGN(CAUSE_ALIGN),
    .CAUSE_IFETCH_BUS(CAUSE_IFETCH_BUS), .CAUSE_DATA_BUS(CAUSE_DATA_BUS)
  ) u_qual (
    .exc_req(exc_req), .exc_cause(exc_cause),
    .exc_addr_vld(exc_addr_vld), .exc_addr(exc_addr),
    .misalign_req(misalign_req), .misalign_addr(misalign_addr),
    .align_trap_en(align_trap_en), .hw_align_en(hw_align_en),
    .buserr_req(buserr_req), .buserr_is_fetch(buserr_is_fetch),
    .buserr_fetch_addr(buserr_fetch_addr), .buserr_data_addr(buserr_data_addr),
    .gen_vld(gen_vld), .gen_cause(gen_cause),
    .gen_addr_vld(gen_addr_vld), .gen_addr(gen_addr)
  );

  exc_arbiter #(.DBG_LEVEL(DBG_LEVEL)) u_arb (
    .busy(take_q), .dbg_req(dbg_req), .cur_lvl(status_q[ILVL_W-1:0]),
    .gen_vld(gen_vld), .dbg_go(dbg_go), .gen_go(gen_go)
  );

  assign enter_double = gen_go & status_q[ST_EXCM_BIT];
  assign write_epc1   = gen_go & (~status_q[ST_EXCM_BIT] | ~USE_DEPC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q   <= '0;
      cause_q    <= '0;
      vaddr_q    <= '0;
      dbgcause_q <= '0;
      epc1_q     <= '0;
      epcdbg_q   <= '0;
      epsdbg_q   <= '0;
      take_q     <= 1'b0;
      vec_q      <= VEC_NONE;
    end else begin
      take_q <= dbg_go | gen_go;
      if (dbg_go) begin
        dbgcause_q <= dbg_cause;
        epcdbg_q   <= cur_pc;
        epsdbg_q   <= status_q;
        status_q   <= debug_status(status_q, DBG_LVL_V);
        vec_q      <= VEC_DEBUG;
      end else if (gen_go) begin
        cause_q <= gen_cause;
        if (gen_addr_vld) vaddr_q <= gen_addr;
        if (write_epc1)   epc1_q  <= cur_pc;
        status_q[ST_EXCM_BIT] <= 1'b1;
        vec_q <= general_vector(status_q[ST_EXCM_BIT], status_q[ST_UM_BIT]);
      end else if (st_load) begin
        status_q <= st_load_val;
      end
    end
  end

  generate
    if (USE_DEPC) begin : g_depc
      always_ff @(posedge clk) begin
        if (!rst_n)            depc_q <= '0;
        else if (enter_double) depc_q <= cur_pc;
      end
    end else begin : g_no_depc
      assign depc_q = '0;
    end
  endgenerate

  always_comb begin
    case (rd_sel)
      RD_STATUS: rd_data = XLEN'(status_q);
      RD_CAUSE:  rd_data = XLEN'(cause_q);
      RD_VADDR:  rd_data = vaddr_q;
      RD_DBGC:   rd_data = XLEN'(dbgcause_q);
      RD_DEPC:   rd_data = depc_q;
      RD_EPC1:   rd_data = epc1_q;
      RD_EPCDBG: rd_data = epcdbg_q;
      default:   rd_data = XLEN'(epsdbg_q);
    endcase
  end

  assign take_o = take_q;
  assign vec_o  = vec_q;

  // R4: pulse lasts one cycle and mode flag is set after any entry
  p_take_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |=> !take_q);
  p_excm_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> status_q[ST_EXCM_BIT]);
  // R2: user vector only from user mode outside exception mode; PC saved
  p_user_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_q && vec_q == VEC_USER) |->
      ($past(status_q[ST_UM_BIT]) && !$past(status_q[ST_EXCM_BIT]) && epc1_q == $past(cur_pc)));
  // R3: double vector only when already in exception mode
  p_double_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_q && vec_q == VEC_DOUBLE) |-> $past(status_q[ST_EXCM_BIT]));
  // R6: debug entry only from below the debug level
  p_debug_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_q && vec_q == VEC_DEBUG) |-> ($past(status_q[ILVL_W-1:0]) < DBG_LVL_V));
  // R7: debug entry raises level and saves the old status
  p_debug_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_q && vec_q == VEC_DEBUG) |->
      (status_q[ILVL_W-1:0] == DBG_LVL_V && epsdbg_q == $past(status_q)));
  // R10: nothing is entered while a pulse is out
  p_busy_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |=> ($stable(cause_q) && $stable(epcdbg_q)));

endmodule

// File: tb/exc_entry_unit_tb.sv
module exc_entry_unit_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cur_pc = '0;
  logic        exc_req = 1'b0;
  logic [5:0]  exc_cause = '0;
  logic        exc_addr_vld = 1'b0;
  logic [31:0] exc_addr = '0;
  logic        misalign_req = 1'b0;
  logic [31:0] misalign_addr = '0;
  logic        align_trap_en = 1'b0;
  logic        hw_align_en = 1'b0;
  logic        buserr_req = 1'b0;
  logic        buserr_is_fetch = 1'b0;
  logic [31:0] buserr_fetch_addr = '0;
  logic [31:0] buserr_data_addr = '0;
  logic        dbg_req = 1'b0;
  logic [3:0]  dbg_cause = '0;
  logic        st_load = 1'b0;
  logic [7:0]  st_load_val = '0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        take_o;
  logic [2:0]  vec_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc),
    .exc_req(exc_req), .exc_cause(exc_cause),
    .exc_addr_vld(exc_addr_vld), .exc_addr(exc_addr),
    .misalign_req(misalign_req), .misalign_addr(misalign_addr),
    .align_trap_en(align_trap_en), .hw_align_en(hw_align_en),
    .buserr_req(buserr_req), .buserr_is_fetch(buserr_is_fetch),
    .buserr_fetch_addr(buserr_fetch_addr), .buserr_data_addr(buserr_data_addr),
    .dbg_req(dbg_req), .dbg_cause(dbg_cause),
    .st_load(st_load), .st_load_val(st_load_val),
    .rd_sel(rd_sel), .rd_data(rd_data), .take_o(take_o), .vec_o(vec_o)
  );

  // kind: 0 plain, 1 with address, 2 misaligned, 3 fetch bus error,
  //       4 data bus error, 5 debug
  typedef struct packed {
    logic [7:0]  st;
    logic [2:0]  kind;
    logic        aen;
    logic        hwa;
    logic [5:0]  cause;
    logic [31:0] pc;
    logic [31:0] addr;
    logic        etake;
    logic [2:0]  evec;
    logic [5:0]  ecause;
    logic        eaddr;
  } tv_t;

  localparam int NTV = 13;
  localparam tv_t TV [NTV] = '{
    '{8'h00, 3'd0, 1'b0, 1'b0, 6'd5,  32'h1000, 32'h0BAD,     1'b1, 3'd1, 6'd5,  1'b0},
    '{8'h20, 3'd1, 1'b0, 1'b0, 6'd28, 32'h2000, 32'hDEAD0000, 1'b1, 3'd2, 6'd28, 1'b1},
    '{8'h10, 3'd0, 1'b0, 1'b0, 6'd7,  32'h3000, 32'h0BAD,     1'b1, 3'd3, 6'd7,  1'b0},
    '{8'h30, 3'd1, 1'b0, 1'b0, 6'd29, 32'h3100, 32'h00000044, 1'b1, 3'd3, 6'd29, 1'b1},
    '{8'h00, 3'd2, 1'b1, 1'b0, 6'd0,  32'h4000, 32'h00001003, 1'b1, 3'd1, 6'd9,  1'b1},
    '{8'h00, 3'd2, 1'b1, 1'b1, 6'd0,  32'h4100, 32'h00002005, 1'b0, 3'd0, 6'd0,  1'b0},
    '{8'h00, 3'd2, 1'b0, 1'b0, 6'd0,  32'h4200, 32'h00003007, 1'b0, 3'd0, 6'd0,  1'b0},
    '{8'h20, 3'd3, 1'b0, 1'b0, 6'd0,  32'h5000, 32'h00008000, 1'b1, 3'd2, 6'd12, 1'b1},
    '{8'h00, 3'd4, 1'b0, 1'b0, 6'd0,  32'h5100, 32'h00009004, 1'b1, 3'd1, 6'd13, 1'b1},
    '{8'h03, 3'd5, 1'b0, 1'b0, 6'd2,  32'h6000, 32'h0,        1'b1, 3'd4, 6'd2,  1'b0},
    '{8'h06, 3'd5, 1'b0, 1'b0, 6'd3,  32'h6100, 32'h0,        1'b0, 3'd0, 6'd0,  1'b0},
    '{8'h25, 3'd5, 1'b0, 1'b0, 6'd1,  32'h7000, 32'h0,        1'b1, 3'd4, 6'd1,  1'b0},
    '{8'h1F, 3'd5, 1'b0, 1'b0, 6'd4,  32'h7100, 32'h0,        1'b0, 3'd0, 6'd0,  1'b0}
  };

  task automatic chk(input string req, input int idx, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s step %0d: actual %h expected %h", req, idx, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] val);
    rd_sel = sel;
    #1;
    val = rd_data;
  endtask

  task automatic idle();
    exc_req = 1'b0; exc_addr_vld = 1'b0; misalign_req = 1'b0;
    buserr_req = 1'b0; dbg_req = 1'b0; st_load = 1'b0;
    align_trap_en = 1'b0; hw_align_en = 1'b0;
  endtask

  task automatic load_status(input logic [7:0] v);
    @(negedge clk);
    idle();
    st_load = 1'b1; st_load_val = v;
    @(negedge clk);
    st_load = 1'b0;
  endtask

  function automatic string tag_of(input tv_t t);
    if (t.kind == 3'd2) return "R8";
    if (t.kind == 3'd3 || t.kind == 3'd4) return "R9";
    if (t.kind == 3'd5) return t.etake ? "R7" : "R6";
    if (t.evec == 3'd3) return "R3";
    return "R2";
  endfunction

  task automatic run_vec(input int i);
    tv_t t;
    logic [31:0] old_va, old_c, old_dc, v, ofs;
    t = TV[i];
    load_status(t.st);
    rd(3'd2, old_va); rd(3'd1, old_c); rd(3'd3, old_dc);
    cur_pc = t.pc;
    ofs = ~t.addr;
    case (t.kind)
      3'd0, 3'd1: begin
        exc_req = 1'b1; exc_cause = t.cause;
        exc_addr = t.addr; exc_addr_vld = (t.kind == 3'd1);
      end
      3'd2: begin
        misalign_req = 1'b1; misalign_addr = t.addr;
        align_trap_en = t.aen; hw_align_en = t.hwa;
      end
      3'd3: begin
        buserr_req = 1'b1; buserr_is_fetch = 1'b1;
        buserr_fetch_addr = t.addr; buserr_data_addr = ofs;
      end
      3'd4: begin
        buserr_req = 1'b1; buserr_is_fetch = 1'b0;
        buserr_fetch_addr = ofs; buserr_data_addr = t.addr;
      end
      default: begin
        dbg_req = 1'b1; dbg_cause = t.cause[3:0];
      end
    endcase
    @(negedge clk);
    idle();
    chk(tag_of(t), i, 32'(take_o), 32'(t.etake));
    if (t.etake) begin
      chk(tag_of(t), i, 32'(vec_o), 32'(t.evec));
      if (t.evec == 3'd4) begin
        rd(3'd3, v); chk("R7", i, v, 32'(t.ecause));
        rd(3'd6, v); chk("R7", i, v, t.pc);
        rd(3'd7, v); chk("R7", i, v, 32'(t.st));
        rd(3'd0, v); chk("R7", i, v, 32'((t.st & 8'hE0) | 8'h16));
        rd(3'd1, v); chk("R7", i, v, old_c);
      end else begin
        rd(3'd1, v); chk("R4", i, v, 32'(t.ecause));
        rd(3'd0, v); chk("R4", i, v, 32'(t.st | 8'h10));
        rd(3'd2, v); chk("R5", i, v, t.eaddr ? t.addr : old_va);
        if (t.evec == 3'd3) begin
          rd(3'd4, v); chk("R3", i, v, t.pc);
          rd(3'd5, v); chk("R3", i, v == t.pc ? 32'd1 : 32'd0, 32'd0);
        end else begin
          rd(3'd5, v); chk("R2", i, v, t.pc);
        end
      end
    end else begin
      rd(3'd0, v); chk(tag_of(t), i, v, 32'(t.st));
      rd(3'd2, v); chk(tag_of(t), i, v, old_va);
      rd(3'd1, v); chk(tag_of(t), i, v, old_c);
      rd(3'd3, v); chk(tag_of(t), i, v, old_dc);
    end
    @(negedge clk);
    chk("R4", i, 32'(take_o), 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] v, c0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1", 100, 32'(take_o), 32'd0);
    chk("R1", 100, 32'(vec_o), 32'd0);
    for (int s = 0; s < 8; s++) begin
      rd(3'(s), v);
      chk("R1", 100 + s, v, 32'd0);
    end

    for (int i = 0; i < NTV; i++) run_vec(i);

    // R10: debug beats a general request; cause register untouched
    load_status(8'h00);
    rd(3'd1, c0);
    cur_pc = 32'hA000;
    dbg_req = 1'b1; dbg_cause = 4'd3; exc_req = 1'b1; exc_cause = 6'd5;
    @(negedge clk); idle();
    chk("R10", 200, 32'(vec_o), 32'd4);
    rd(3'd3, v); chk("R10", 200, v, 32'd3);
    rd(3'd1, v); chk("R10", 200, v, c0);

    // R10: explicit request beats a bus error
    load_status(8'h00);
    rd(3'd2, c0);
    exc_req = 1'b1; exc_cause = 6'd21;
    buserr_req = 1'b1; buserr_is_fetch = 1'b0; buserr_data_addr = 32'h44;
    @(negedge clk); idle();
    rd(3'd1, v); chk("R10", 201, v, 32'd21);
    rd(3'd2, v); chk("R10", 201, v, c0);

    // R10: bus error beats a qualified misaligned access
    load_status(8'h00);
    buserr_req = 1'b1; buserr_is_fetch = 1'b1; buserr_fetch_addr = 32'h300;
    misalign_req = 1'b1; misalign_addr = 32'h7; align_trap_en = 1'b1;
    @(negedge clk); idle();
    rd(3'd1, v); chk("R10", 202, v, 32'd12);
    rd(3'd2, v); chk("R10", 202, v, 32'h300);

    // R10: request held while the pulse is out is dropped
    load_status(8'h00);
    exc_req = 1'b1; exc_cause = 6'd5; cur_pc = 32'hB000;
    @(negedge clk);
    chk("R10", 203, 32'(take_o), 32'd1);
    exc_cause = 6'd8; cur_pc = 32'hB004;
    @(negedge clk); idle();
    chk("R10", 203, 32'(take_o), 32'd0);
    rd(3'd1, v); chk("R10", 203, v, 32'd5);
    rd(3'd4, v); chk("R10", 203, v == 32'hB004 ? 32'd1 : 32'd0, 32'd0);

    // R11: exception at the same edge as a status load wins
    load_status(8'h00);
    st_load = 1'b1; st_load_val = 8'h20;
    exc_req = 1'b1; exc_cause = 6'd6;
    @(negedge clk); idle();
    chk("R11", 204, 32'(vec_o), 32'd1);
    rd(3'd0, v); chk("R11", 204, v, 32'h10);

    // R11 / R12: full status load, zero-extended on the read port
    load_status(8'hFF);
    rd(3'd0, v); chk("R12", 205, v, 32'h000000FF);
    chk("R11", 205, 32'(take_o), 32'd0);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule